// File: doc/BRIEF.md
# XY Wormhole Mesh Router

This block is a five-port switch for one node of a two-dimensional mesh. The ports face east, west, north, south and the local node. Every incoming port writes into its own FIFO. When a packet reaches the head of a FIFO, the router reads the target coordinates from its first flit and chooses an output by dimension-ordered XY routing. It then asks for that output. A round-robin arbiter settles any contention for the output.

After the grant, the input and the output stay tied to each other until the last flit of the packet has crossed. Flits move one per cycle through a crossbar. They move only while the downstream side signals that it can accept one. A stall holds the packet where it is and drops nothing.

Meshes are built by wiring an output of one router to the matching input of its neighbour. The `out_ready` of each port is driven by the receiving FIFO's `in_ready`.

Top module: `mesh_router`

## Requirements
- R1: While reset is held, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: The X coordinate is resolved first. A packet whose target X (flit 0, bits [15:8]) is above the router's `X_POS` leaves on port 0 (east). A packet whose target X is below `X_POS` leaves on port 1 (west). This holds whatever the target Y is.
- R3: When the target X equals `X_POS`, a target Y (flit 0, bits [7:0]) above `Y_POS` leaves on port 2 (north), and one below `Y_POS` leaves on port 3 (south). When both coordinates match, the packet leaves on port 4 (local).
- R4: A packet is a header flit, then a length flit whose bits [15:0] give N, then N payload flits. All 2+N flits, header included, leave unchanged and in order on the chosen output.
- R5: Once an output is granted to a packet, it carries only that packet's flits until the packet's last flit. A packet's flits are never interleaved with another packet's flits.
- R6: An input stays bound to its granted output until its packet ends. Packets from one input leave in the order they arrived.
- R7: An output is granted at most one cycle after the request, if the output is free. Among several requesters, the search starts just after the previous winner. After reset the search starts at port 0.
- R8: While `out_ready` of a port is low, that port's `out_valid` and `out_data` hold steady. No flit is lost or repeated.
- R9: A flit is accepted when `in_valid` and `in_ready` are both high. `in_ready` drops while that input's FIFO holds `FIFO_DEPTH` flits.
- R10: A packet with N = 0 releases its input and its output right after its length flit.
- R11: Packets that use different inputs and different outputs move in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 5*FLIT_W | Incoming flits, port p in bits [p*FLIT_W +: FLIT_W] |
| in_valid | input | 5 | An incoming flit is present, one bit per port |
| in_ready | output | 5 | The input FIFO has room, one bit per port |
| out_data | output | 5*FLIT_W | Outgoing flits, port p in bits [p*FLIT_W +: FLIT_W] |
| out_valid | output | 5 | An outgoing flit is present, one bit per port |
| out_ready | input | 5 | The downstream side can take a flit, one bit per port |

## Verification
Assertions check these properties on every cycle:
- a locked output keeps its owner until the owning input sends its last flit;
- a bound input keeps its chosen output until the same point;
- each arbiter grants at most one requester;
- a stalled output keeps its flit steady;
- FIFO occupancy rises by exactly one on a push without a pop.

The following can only be shown by the bench scenarios, which compare against a behavioural reference model on every clock:
- that the XY decision picks the right port for each coordinate case;
- the rotation order among competing inputs;
- that packets of any length arrive whole and in order;
- that zero-length packets release at once;
- that separate connections overlap in time.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int NUM_PORTS = 5;

  typedef enum logic [2:0] {
    PORT_E = 3'd0,
    PORT_W = 3'd1,
    PORT_N = 3'd2,
    PORT_S = 3'd3,
    PORT_L = 3'd4
  } port_e;

  typedef enum logic [1:0] {
    ST_HEAD = 2'd0,
    ST_LEN  = 2'd1,
    ST_BODY = 2'd2
  } stage_e;
endpackage

// File: rtl/router_fifo.sv
module router_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];
  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (wr_en && !rd_en)      count <= count + 1'b1;
      else if (!wr_en && rd_en) count <= count - 1'b1;
    end
  end

  // R9
  fifo_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/router_xy_route.sv
module router_xy_route
  import router_pkg::*;
#(
  parameter int COORD_W = 8,
  parameter int X_POS   = 1,
  parameter int Y_POS   = 1
) (
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  output port_e              dir
);
  localparam logic [COORD_W-1:0] MY_X = COORD_W'(X_POS);
  localparam logic [COORD_W-1:0] MY_Y = COORD_W'(Y_POS);

  always_comb begin
    if (dst_x > MY_X)      dir = PORT_E;
    else if (dst_x < MY_X) dir = PORT_W;
    else if (dst_y > MY_Y) dir = PORT_N;
    else if (dst_y < MY_Y) dir = PORT_S;
    else                   dir = PORT_L;
  end
endmodule

// File: rtl/router_rr_arb.sv
module router_rr_arb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q;

  always_comb begin
    gnt = '0;
    if (enable) begin
      for (int k = 1; k <= N; k++) begin
        if (req[(int'(last_q) + k) % N] && (gnt == '0))
          gnt[(int'(last_q) + k) % N] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= IW'(N - 1);
    end else begin
      for (int i = 0; i < N; i++) begin
        if (gnt[i]) last_q <= IW'(i);
      end
    end
  end

  // R7
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import router_pkg::*;
#(
  parameter int FLIT_W     = 32,
  parameter int FIFO_DEPTH = 256,
  parameter int COORD_W    = 8,
  parameter int LEN_W      = 16,
  parameter int X_POS      = 1,
  parameter int Y_POS      = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_PORTS*FLIT_W-1:0]   in_data,
  input  logic [NUM_PORTS-1:0]          in_valid,
  output logic [NUM_PORTS-1:0]          in_ready,
  output logic [NUM_PORTS*FLIT_W-1:0]   out_data,
  output logic [NUM_PORTS-1:0]          out_valid,
  input  logic [NUM_PORTS-1:0]          out_ready
);
  localparam int NP = NUM_PORTS;
  localparam int PW = $clog2(NP);

  logic [FLIT_W-1:0] head [NP];
  logic [NP-1:0]     f_empty, f_full, push, pop, last, release_in, busy_q, granted;
  port_e             want [NP];
  logic [PW-1:0]     sel_q [NP];
  stage_e            stage_q [NP];
  logic [LEN_W-1:0]  cnt_q [NP];
  logic [NP-1:0]     lock_q;
  logic [PW-1:0]     owner_q [NP];
  logic [NP-1:0]     req_to [NP];
  logic [NP-1:0]     gnt_to [NP];

  // Input side: buffer, route decision and packet tracking
  for (genvar i = 0; i < NP; i++) begin : g_in
    router_fifo #(.W(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (push[i]),
      .wr_data (in_data[i*FLIT_W +: FLIT_W]),
      .rd_en   (pop[i]),
      .rd_data (head[i]),
      .empty   (f_empty[i]),
      .full    (f_full[i])
    );

    router_xy_route #(.COORD_W(COORD_W), .X_POS(X_POS), .Y_POS(Y_POS)) u_route (
      .dst_x (head[i][2*COORD_W-1:COORD_W]),
      .dst_y (head[i][COORD_W-1:0]),
      .dir   (want[i])
    );

    assign in_ready[i]   = !f_full[i];
    assign push[i]       = in_valid[i] && !f_full[i];
    assign pop[i]        = busy_q[i] && !f_empty[i] && out_ready[sel_q[i]];
    assign last[i]       = ((stage_q[i] == ST_LEN)  && (head[i][LEN_W-1:0] == '0)) ||
                           ((stage_q[i] == ST_BODY) && (cnt_q[i] == LEN_W'(1)));
    assign release_in[i] = pop[i] && last[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        busy_q[i]  <= 1'b0;
        sel_q[i]   <= '0;
        stage_q[i] <= ST_HEAD;
        cnt_q[i]   <= '0;
      end else if (!busy_q[i]) begin
        if (granted[i]) begin
          busy_q[i]  <= 1'b1;
          sel_q[i]   <= PW'(want[i]);
          stage_q[i] <= ST_HEAD;
        end
      end else if (pop[i]) begin
        case (stage_q[i])
          ST_HEAD: stage_q[i] <= ST_LEN;
          ST_LEN: begin
            cnt_q[i]   <= head[i][LEN_W-1:0];
            stage_q[i] <= ST_BODY;
          end
          default: cnt_q[i] <= cnt_q[i] - 1'b1;
        endcase
        if (last[i]) begin
          busy_q[i]  <= 1'b0;
          stage_q[i] <= ST_HEAD;
        end
      end
    end

    // R6
    in_lock_chk: assert property (@(posedge clk) disable iff (rst)
      (busy_q[i] && !release_in[i]) |=> (busy_q[i] && $stable(sel_q[i])));
  end

  // Request matrix: an idle input with a waiting header asks for its port
  always_comb begin
    for (int o = 0; o < NP; o++) begin
      for (int i = 0; i < NP; i++) begin
        req_to[o][i] = !busy_q[i] && !f_empty[i] && (int'(want[i]) == o);
      end
    end
  end

  always_comb begin
    granted = '0;
    for (int o = 0; o < NP; o++) granted = granted | gnt_to[o];
  end

  // Output side: arbitration, connection lock and crossbar
  for (genvar o = 0; o < NP; o++) begin : g_out
    router_rr_arb #(.N(NP)) u_arb (
      .clk    (clk),
      .rst    (rst),
      .enable (!lock_q[o]),
      .req    (req_to[o]),
      .gnt    (gnt_to[o])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        lock_q[o]  <= 1'b0;
        owner_q[o] <= '0;
      end else if (!lock_q[o]) begin
        for (int i = 0; i < NP; i++) begin
          if (gnt_to[o][i]) begin
            lock_q[o]  <= 1'b1;
            owner_q[o] <= PW'(i);
          end
        end
      end else if (release_in[owner_q[o]]) begin
        lock_q[o] <= 1'b0;
      end
    end

    assign out_valid[o]                 = lock_q[o] && !f_empty[owner_q[o]];
    assign out_data[o*FLIT_W +: FLIT_W] = head[owner_q[o]];

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (lock_q[o] && !release_in[owner_q[o]]) |=> (lock_q[o] && $stable(owner_q[o])));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid[o] && !out_ready[o]) |=>
        (out_valid[o] && $stable(out_data[o*FLIT_W +: FLIT_W])));
  end
endmodule

// File: tb/test_mesh_router.sv
module test_mesh_router;
  import router_pkg::*;
  localparam int NP = NUM_PORTS;
  localparam int W  = 32;
  localparam int D  = 4;
  localparam int MX = 2;
  localparam int MY = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [NP*W-1:0] in_data = '0;
  logic [NP*W-1:0] out_data;
  logic [NP-1:0]   in_valid = '0, in_ready, out_valid;
  logic [NP-1:0]   out_ready = '1;

  mesh_router #(.FLIT_W(W), .FIFO_DEPTH(D), .COORD_W(8), .LEN_W(16),
                .X_POS(MX), .Y_POS(MY)) i_mesh_router (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready));

  int checks = 0, fails = 0;
  logic [31:0] feed [NP][$];
  logic [31:0] mq [NP][$];
  logic [31:0] m_log [NP][$];
  logic [31:0] rtl_log [NP][$];
  int m_busy [NP], m_sel [NP], m_stage [NP], m_cnt [NP];
  int m_lock [NP], m_own [NP], m_ptr [NP];
  bit rand_ready = 0;
  logic [NP-1:0] ready_force = '1;
  bit both_seen = 0;

  function automatic int route(logic [31:0] h);
    if (h[15:8] > 8'(MX)) return 0;
    if (h[15:8] < 8'(MX)) return 1;
    if (h[7:0] > 8'(MY)) return 2;
    if (h[7:0] < 8'(MY)) return 3;
    return 4;
  endfunction

  task automatic check(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NP; i++) begin
        mq[i].delete();
        m_busy[i] = 0; m_sel[i] = 0; m_stage[i] = 0; m_cnt[i] = 0;
        m_lock[i] = 0; m_own[i] = 0; m_ptr[i] = NP - 1;
      end
    end else begin
      int gi [NP];
      int pre_sz [NP];
      bit rel [NP];
      for (int i = 0; i < NP; i++) begin
        pre_sz[i] = mq[i].size();
        rel[i] = 0;
        gi[i] = -1;
      end
      for (int o = 0; o < NP; o++) begin
        if (m_lock[o] == 0) begin
          for (int k = 1; k <= NP; k++) begin
            int c;
            c = (m_ptr[o] + k) % NP;
            if (gi[o] < 0 && m_busy[c] == 0 && mq[c].size() > 0 && route(mq[c][0]) == o)
              gi[o] = c;
          end
        end
      end
      for (int i = 0; i < NP; i++) begin
        if (m_busy[i] != 0 && mq[i].size() > 0 && out_ready[m_sel[i]]) begin
          logic [31:0] f;
          f = mq[i].pop_front();
          m_log[m_sel[i]].push_back(f);
          if (m_stage[i] == 0) m_stage[i] = 1;
          else if (m_stage[i] == 1) begin
            m_cnt[i] = int'(f[15:0]);
            m_stage[i] = 2;
            if (m_cnt[i] == 0) rel[i] = 1;
          end else begin
            m_cnt[i]--;
            if (m_cnt[i] == 0) rel[i] = 1;
          end
        end
      end
      for (int o = 0; o < NP; o++) begin
        if (gi[o] >= 0) begin
          m_lock[o] = 1; m_own[o] = gi[o]; m_ptr[o] = gi[o];
          m_busy[gi[o]] = 1; m_sel[gi[o]] = o; m_stage[gi[o]] = 0;
        end
      end
      for (int i = 0; i < NP; i++) begin
        if (rel[i]) begin
          m_lock[m_sel[i]] = 0;
          m_busy[i] = 0;
          m_stage[i] = 0;
        end
      end
      for (int i = 0; i < NP; i++) begin
        if (in_valid[i] && pre_sz[i] < D) begin
          mq[i].push_back(in_data[i*W +: W]);
          void'(feed[i].pop_front());
        end
      end
    end
  end

  // One cycle: compare at the falling edge, drive, then log RTL transfers
  task automatic step();
    @(negedge clk);
    for (int o = 0; o < NP; o++) begin
      bit ev;
      ev = (m_lock[o] != 0) && (mq[m_own[o]].size() > 0);
      check(out_valid[o] == ev, "R5", $sformatf("out_valid[%0d]", o), 32'(out_valid[o]), 32'(ev));
      if (ev) check(out_data[o*W +: W] == mq[m_own[o]][0], "R4",
                    $sformatf("out_data[%0d]", o), out_data[o*W +: W], mq[m_own[o]][0]);
    end
    for (int i = 0; i < NP; i++)
      check(in_ready[i] == (mq[i].size() < D), "R9", $sformatf("in_ready[%0d]", i),
            32'(in_ready[i]), 32'(mq[i].size() < D));
    if (out_valid[0] && out_valid[1]) both_seen = 1;
    for (int i = 0; i < NP; i++) begin
      in_valid[i] = feed[i].size() > 0;
      in_data[i*W +: W] = (feed[i].size() > 0) ? feed[i][0] : 32'h0;
    end
    out_ready = rand_ready ? NP'($urandom) : ready_force;
    #5;
    for (int o = 0; o < NP; o++)
      if (out_valid[o] && out_ready[o]) rtl_log[o].push_back(out_data[o*W +: W]);
  endtask

  function automatic bit idle();
    for (int i = 0; i < NP; i++)
      if (feed[i].size() > 0 || mq[i].size() > 0 || m_lock[i] != 0) return 0;
    return 1;
  endfunction

  task automatic drain(int maxc);
    int n = 0;
    while (!idle() && n < maxc) begin
      step();
      n++;
    end
    check(n < maxc, "R5", "drain finished", 32'(n), 32'(maxc));
    repeat (3) step();
  endtask

  task automatic cmp_logs(string rq);
    for (int o = 0; o < NP; o++) begin
      check(rtl_log[o].size() == m_log[o].size(), rq, $sformatf("flit count port %0d", o),
            32'(rtl_log[o].size()), 32'(m_log[o].size()));
      for (int k = 0; k < rtl_log[o].size() && k < m_log[o].size(); k++)
        if (rtl_log[o][k] != m_log[o][k])
          check(0, rq, $sformatf("flit %0d port %0d", k, o), rtl_log[o][k], m_log[o][k]);
    end
  endtask

  task automatic clear_logs();
    for (int o = 0; o < NP; o++) begin
      rtl_log[o].delete();
      m_log[o].delete();
    end
  endtask

  task automatic send(int i, int x, int y, int len, int tag);
    feed[i].push_back({16'h0, 8'(x), 8'(y)});
    feed[i].push_back(32'(len));
    for (int k = 0; k < len; k++) feed[i].push_back({8'(tag), 8'(i), 16'(k)});
  endtask

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] sent [$];
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid == '0, "R1", "out_valid in reset", 32'(out_valid), 32'h0);
    check(in_ready == '1, "R1", "in_ready in reset", 32'(in_ready), 32'h1f);
    rst = 1'b0;

    // R2 / R3: every direction from the local input
    send(4, 3, 0, 2, 1);   // X first: east although Y is lower
    send(4, 1, 5, 1, 2);   // west
    send(4, 2, 5, 0, 3);   // north
    send(4, 2, 0, 1, 4);   // south
    send(4, 2, 2, 2, 5);   // local
    drain(400);
    check(rtl_log[0].size() == 4 && rtl_log[0][0] == 32'h0300, "R2", "east header",
          rtl_log[0].size() > 0 ? rtl_log[0][0] : 32'hx, 32'h0300);
    check(rtl_log[1].size() == 3 && rtl_log[1][0] == 32'h0105, "R2", "west header",
          rtl_log[1].size() > 0 ? rtl_log[1][0] : 32'hx, 32'h0105);
    check(rtl_log[2].size() == 2 && rtl_log[2][0] == 32'h0205, "R3", "north header",
          rtl_log[2].size() > 0 ? rtl_log[2][0] : 32'hx, 32'h0205);
    check(rtl_log[3].size() == 3 && rtl_log[3][0] == 32'h0200, "R3", "south header",
          rtl_log[3].size() > 0 ? rtl_log[3][0] : 32'hx, 32'h0200);
    check(rtl_log[4].size() == 4 && rtl_log[4][0] == 32'h0202, "R3", "local header",
          rtl_log[4].size() > 0 ? rtl_log[4][0] : 32'hx, 32'h0202);
    cmp_logs("R4");
    clear_logs();

    // R7: three inputs contend for local, two packets each
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < 3; i++) send(i, 2, 2, 1, 8'h70 + r);
    drain(400);
    check(rtl_log[4].size() == 18, "R7", "local flit count", 32'(rtl_log[4].size()), 32'd18);
    for (int k = 0; k < 6 && rtl_log[4].size() == 18; k++) begin
      check(rtl_log[4][3*k+2][23:16] == 8'(k % 3), "R7", $sformatf("winner %0d", k),
            32'(rtl_log[4][3*k+2][23:16]), 32'(k % 3));
      check(rtl_log[4][3*k] == 32'h0202 && rtl_log[4][3*k+1] == 32'h1, "R5",
            $sformatf("packet %0d not interleaved", k), rtl_log[4][3*k], 32'h0202);
    end
    cmp_logs("R6");
    clear_logs();

    // R8 / R9: north stalled while a long packet fills the FIFO
    ready_force = 5'b11011;
    send(4, 2, 6, 6, 8'h80);
    sent = feed[4];
    repeat (12) step();
    check(in_ready[4] == 1'b0, "R9", "in_ready low when full", 32'(in_ready[4]), 32'h0);
    check(out_valid[2] == 1'b1, "R8", "valid held under stall", 32'(out_valid[2]), 32'h1);
    check(out_data[2*W +: W] == 32'h0206, "R8", "data held under stall", out_data[2*W +: W], 32'h0206);
    ready_force = '1;
    drain(400);
    check(rtl_log[2].size() == sent.size(), "R8", "no flit lost", 32'(rtl_log[2].size()), 32'(sent.size()));
    for (int k = 0; k < sent.size() && k < rtl_log[2].size(); k++)
      check(rtl_log[2][k] == sent[k], "R8", $sformatf("flit %0d intact", k), rtl_log[2][k], sent[k]);
    clear_logs();

    // R10: back-to-back empty packets
    send(3, 4, 1, 0, 0);
    send(3, 4, 1, 0, 0);
    drain(200);
    check(rtl_log[0].size() == 4, "R10", "empty packets", 32'(rtl_log[0].size()), 32'd4);
    if (rtl_log[0].size() == 4)
      check(rtl_log[0][2] == 32'h0401 && rtl_log[0][3] == 32'h0, "R10", "second empty packet",
            rtl_log[0][2], 32'h0401);
    cmp_logs("R10");
    clear_logs();

    // R11: two independent connections at once
    both_seen = 0;
    send(0, 0, 2, 3, 8'h90);
    send(1, 4, 2, 3, 8'h91);
    drain(200);
    check(both_seen, "R11", "east and west active together", 32'(both_seen), 32'h1);
    cmp_logs("R11");
    clear_logs();

    // Mixed traffic with random back-pressure
    rand_ready = 1;
    for (int r = 0; r < 40; r++) begin
      int src;
      src = r % NP;
      send(src, int'($urandom % 5), int'($urandom % 5), int'($urandom % 4), r);
    end
    drain(5000);
    rand_ready = 0;
    cmp_logs("R6");
    clear_logs();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule